// File: doc/BRIEF.md
# Per-Frame Generation Count Validator

This block sits at the memory side of a shared-memory system and decides whether an incoming access may use memory. A requester translates a virtual page to a frame through its own translation entry and sends the frame number with the request. It also sends the generation count it captured when that entry was loaded. The validator keeps a table with one current count per frame. In a single clock edge it compares the carried count with the table count and, when they agree, performs the read or write on the memory stub. When they disagree, the response tells the requester that its entry is stale and must be dropped. The response also returns the frame's current count so that the requester can reload a fresh translation.

Before a mapping change that could leave translations unsafe, the operating system multicasts an update for the frame. The update raises the count, so every older translation now fails the check. An update can also lock the frame for the length of the remap. A locked frame answers any request with a busy code and leaves memory untouched. Each update is acknowledged, and the mapping change may proceed only after the acknowledge. The cluster's memory modules each hold their own copy of the table. All copies take the same multicast update, and the request's module select picks both the copy that is consulted and the memory bank.

Top module: `gcv_validator`

## Requirements
- R1: After reset every frame's count is 0 and no frame is locked. `rsp_valid` and `upd_ack` are low while reset is held.
- R2: A request to an unlocked frame whose carried count equals the table count gets response code OK (0). `rsp_cur_gen` returns the table count. `rsp_code` is never 3.
- R3: A request to an unlocked frame whose carried count differs from the table count gets code STALE (1), with `rsp_cur_gen` set to the table count. A stale write does not change memory.
- R4: An OK write stores `req_wdata` at (module, frame, word). An OK read returns the stored word on `rsp_rdata`. `rsp_rdata` is 0 for any response other than an OK read.
- R5: An update with op BUMP (0) raises the frame's count by one modulo 16, so that 15 wraps to 0.
- R6: An update with op LOCK (1) raises the count by one and locks the frame. Requests to a locked frame get code BUSY (2) whatever count they carry, and they do not write memory. Op UNLOCK (2) clears the lock and leaves the count unchanged.
- R7: When an update and a request for the same frame fall in the same cycle, the request is judged against the count and lock state left by the update.
- R8: `upd_ack` is high in exactly the cycle after each cycle with `upd_valid`, and low otherwise.
- R9: An update changes the table copy of every module. A request to any module is checked against the same count, and each module has its own memory words.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid`.
- R11: An update with op NOP (3) leaves count and lock unchanged but is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mod | input | 1 | Memory module (table copy and bank) addressed |
| req_frame | input | 6 | Frame number |
| req_word | input | 3 | Word within the frame |
| req_write | input | 1 | 1 = write, 0 = read |
| req_gen | input | 4 | Generation count from the requester's translation entry |
| req_wdata | input | 16 | Write data |
| upd_valid | input | 1 | Multicast update present this cycle |
| upd_op | input | 2 | 0 BUMP, 1 LOCK, 2 UNLOCK, 3 NOP |
| upd_frame | input | 6 | Frame the update targets |
| upd_ack | output | 1 | Update acknowledge, one cycle after the update |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 1 STALE, 2 BUSY |
| rsp_cur_gen | output | 4 | Table count the request was judged against |
| rsp_rdata | output | 16 | Read data for an OK read, otherwise 0 |

## Verification
The request check and the count update can land on one frame in the same cycle. The bench provokes this by driving a request and a BUMP or LOCK to the same frame at one clock edge, with the carried count equal first to the old value and then to the new one. Its reference model always applies the update first and then judges the request. A design that lets the request read the old count therefore shows a code or `rsp_cur_gen` that differs from the model. A random phase then mixes updates and requests over a small set of frames, so that these collisions also occur in many unplanned combinations.

// File: rtl/gcv_pkg.sv
package gcv_pkg;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_STALE = 2'd1,
    RSP_BUSY  = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    UPD_BUMP   = 2'd0,
    UPD_LOCK   = 2'd1,
    UPD_UNLOCK = 2'd2,
    UPD_NOP    = 2'd3
  } upd_op_e;

  // Verdict for one request: a lock overrides any count comparison.
  function automatic rsp_code_e classify(input logic locked, input logic same_gen);
    if (locked)        return RSP_BUSY;
    else if (same_gen) return RSP_OK;
    else               return RSP_STALE;
  endfunction

endpackage

// File: rtl/gcv_gen_table.sv
module gcv_gen_table
  import gcv_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int GEN_W  = 4,
  localparam int FRAME_W = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [1:0]         upd_op,
  input  logic [FRAME_W-1:0] upd_frame,
  input  logic [FRAME_W-1:0] look_frame,
  output logic [GEN_W-1:0]   look_gen,
  output logic               look_lock
);

  logic [GEN_W-1:0]  gen_q [FRAMES];
  logic [FRAMES-1:0] lock_q;

  upd_op_e          op_e;
  logic             wr_en;
  logic [GEN_W-1:0] wr_gen;
  logic             wr_lock;
  logic             same_frame;

  function automatic logic [GEN_W-1:0] advance(input logic [GEN_W-1:0] g);
    return g + GEN_W'(1);
  endfunction

  assign op_e  = upd_op_e'(upd_op);
  assign wr_en = upd_valid && (op_e != UPD_NOP);

  always_comb begin
    wr_gen  = gen_q[upd_frame];
    wr_lock = lock_q[upd_frame];
    case (op_e)
      UPD_BUMP:   wr_gen = advance(gen_q[upd_frame]);
      UPD_LOCK: begin
        wr_gen  = advance(gen_q[upd_frame]);
        wr_lock = 1'b1;
      end
      UPD_UNLOCK: wr_lock = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAMES; i++) gen_q[i] <= '0;
      lock_q <= '0;
    end else if (wr_en) begin
      gen_q[upd_frame]  <= wr_gen;
      lock_q[upd_frame] <= wr_lock;
    end
  end

  // Look-through: a same-cycle update to the looked-up frame is seen at once.
  assign same_frame = upd_valid && (upd_frame == look_frame);
  assign look_gen   = same_frame ? wr_gen  : gen_q[look_frame];
  assign look_lock  = same_frame ? wr_lock : lock_q[look_frame];

endmodule

// File: rtl/gcv_judge.sv
module gcv_judge
  import gcv_pkg::*;
#(
  parameter int GEN_W = 4
) (
  input  logic             locked,
  input  logic [GEN_W-1:0] table_gen,
  input  logic [GEN_W-1:0] carried_gen,
  output logic [1:0]       code,
  output logic             grant
);

  rsp_code_e verdict;

  assign verdict = classify(locked, table_gen == carried_gen);
  assign code    = verdict;
  assign grant   = (verdict == RSP_OK);

endmodule

// File: rtl/gcv_mem_stub.sv
module gcv_mem_stub #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= re ? cells[addr] : '0;
  end

endmodule

// File: rtl/gcv_validator.sv
module gcv_validator
  import gcv_pkg::*;
#(
  parameter int FRAMES   = 64,
  parameter int GEN_W    = 4,
  parameter int WORDS    = 8,
  parameter int DATA_W   = 16,
  parameter int REPLICAS = 2,
  localparam int FRAME_W = $clog2(FRAMES),
  localparam int WORD_W  = $clog2(WORDS),
  localparam int MOD_W   = (REPLICAS > 1) ? $clog2(REPLICAS) : 1,
  localparam int ADDR_W  = MOD_W + FRAME_W + WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [MOD_W-1:0]   req_mod,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [WORD_W-1:0]  req_word,
  input  logic               req_write,
  input  logic [GEN_W-1:0]   req_gen,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               upd_valid,
  input  logic [1:0]         upd_op,
  input  logic [FRAME_W-1:0] upd_frame,
  output logic               upd_ack,
  output logic               rsp_valid,
  output logic [1:0]         rsp_code,
  output logic [GEN_W-1:0]   rsp_cur_gen,
  output logic [DATA_W-1:0]  rsp_rdata
);

  // Per-module table copies, all written by the same multicast update.
  logic [GEN_W-1:0]          look_gen_all  [REPLICAS];
  logic                      look_lock_all [REPLICAS];
  logic [REPLICAS*GEN_W-1:0] look_gen_flat;
  logic [REPLICAS-1:0]       look_lock_flat;

  for (genvar r = 0; r < REPLICAS; r++) begin : g_copy
    gcv_gen_table #(
      .FRAMES (FRAMES),
      .GEN_W  (GEN_W)
    ) table_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_valid  (upd_valid),
      .upd_op     (upd_op),
      .upd_frame  (upd_frame),
      .look_frame (req_frame),
      .look_gen   (look_gen_all[r]),
      .look_lock  (look_lock_all[r])
    );
    assign look_gen_flat[r*GEN_W +: GEN_W] = look_gen_all[r];
    assign look_lock_flat[r]               = look_lock_all[r];
  end

  // Named internal events, brought out for the checker.
  logic [GEN_W-1:0] sel_gen;
  logic             sel_lock;
  logic [1:0]       code_w;
  logic             grant_w;
  logic             mem_we_w;
  logic             mem_re_w;

  assign sel_gen  = look_gen_all[req_mod];
  assign sel_lock = look_lock_all[req_mod];

  gcv_judge #(.GEN_W(GEN_W)) judge_i (
    .locked      (sel_lock),
    .table_gen   (sel_gen),
    .carried_gen (req_gen),
    .code        (code_w),
    .grant       (grant_w)
  );

  // The compare and the access resolve at one clock edge: nothing intervenes.
  assign mem_we_w = req_valid && grant_w &&  req_write;
  assign mem_re_w = req_valid && grant_w && !req_write;

  gcv_mem_stub #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we_w),
    .re    (mem_re_w),
    .addr  ({req_mod, req_frame, req_word}),
    .wdata (req_wdata),
    .rdata (rsp_rdata)
  );

  logic             rsp_valid_q;
  logic [1:0]       rsp_code_q;
  logic [GEN_W-1:0] rsp_gen_q;
  logic             upd_ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_gen_q   <= '0;
      upd_ack_q   <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_code_q  <= code_w;
      rsp_gen_q   <= sel_gen;
      upd_ack_q   <= upd_valid;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_code    = rsp_code_q;
  assign rsp_cur_gen = rsp_gen_q;
  assign upd_ack     = upd_ack_q;

endmodule

// File: rtl/gcv_validator_chk.sv
module gcv_validator_chk #(
  parameter int GEN_W    = 4,
  parameter int REPLICAS = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [GEN_W-1:0]          req_gen,
  input logic                      upd_valid,
  input logic                      upd_ack,
  input logic                      rsp_valid,
  input logic [1:0]                rsp_code,
  input logic [GEN_W-1:0]          rsp_cur_gen,
  input logic                      sel_lock,
  input logic                      mem_we_w,
  input logic [REPLICAS*GEN_W-1:0] look_gen_flat,
  input logic [REPLICAS-1:0]       look_lock_flat
);

  logic copies_agree;
  always_comb begin
    copies_agree = 1'b1;
    for (int r = 1; r < REPLICAS; r++) begin
      if (look_gen_flat[r*GEN_W +: GEN_W] != look_gen_flat[GEN_W-1:0]) copies_agree = 1'b0;
      if (look_lock_flat[r] != look_lock_flat[0]) copies_agree = 1'b0;
    end
  end

  p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> upd_ack);
  p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> !upd_ack);
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_locked_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_lock) |=> (rsp_code == 2'd2));
  p_write_only_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_w |=> (rsp_code == 2'd0));
  p_stale_differs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd1) |-> (rsp_cur_gen != $past(req_gen)));
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));
  p_copies_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> copies_agree);

endmodule

bind gcv_validator gcv_validator_chk #(
  .GEN_W    (GEN_W),
  .REPLICAS (REPLICAS)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_gen        (req_gen),
  .upd_valid      (upd_valid),
  .upd_ack        (upd_ack),
  .rsp_valid      (rsp_valid),
  .rsp_code       (rsp_code),
  .rsp_cur_gen    (rsp_cur_gen),
  .sel_lock       (sel_lock),
  .mem_we_w       (mem_we_w),
  .look_gen_flat  (look_gen_flat),
  .look_lock_flat (look_lock_flat)
);

// File: tb/gcv_validator_tb.sv
`timescale 1ns/1ps
module gcv_validator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [0:0]  req_mod = '0;
  logic [5:0]  req_frame = '0;
  logic [2:0]  req_word = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_gen = '0;
  logic [15:0] req_wdata = '0;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_op = '0;
  logic [5:0]  upd_frame = '0;
  logic        upd_ack;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [3:0]  rsp_cur_gen;
  logic [15:0] rsp_rdata;

  always #2 clk = ~clk;  // 250 MHz

  gcv_validator dut_i (.*);

  typedef struct {
    logic        valid;
    logic [1:0]  code;
    logic [3:0]  gen;
    logic [15:0] rdata;
    logic        ack;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference model
  int          gen_m  [64];
  bit          lock_m [64];
  logic [15:0] mem_m  [2][64][8];

  localparam int OK = 0, STALE = 1, BUSY = 2;
  localparam int BUMP = 0, LOCK = 1, UNLOCK = 2, NOP = 3;

  task automatic step(input bit rv, input int m, input int f, input int w,
                      input bit wr, input int g, input logic [15:0] wd,
                      input bit uv, input int op, input int uf, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_mod = 1'(m); req_frame = 6'(f); req_word = 3'(w);
    req_write = wr; req_gen = 4'(g); req_wdata = wd;
    upd_valid = uv; upd_op = 2'(op); upd_frame = 6'(uf);
    // update first, then judge (same-frame collision rule)
    if (uv) begin
      if (op == BUMP) gen_m[uf] = (gen_m[uf] + 1) % 16;
      else if (op == LOCK) begin gen_m[uf] = (gen_m[uf] + 1) % 16; lock_m[uf] = 1; end
      else if (op == UNLOCK) lock_m[uf] = 0;
    end
    e.valid = rv; e.ack = uv; e.code = 0; e.gen = 0; e.rdata = 0; e.tag = tag;
    if (rv) begin
      e.gen = 4'(gen_m[f]);
      if (lock_m[f]) e.code = 2'(BUSY);
      else if (g != gen_m[f]) e.code = 2'(STALE);
      else begin
        e.code = 2'(OK);
        if (wr) mem_m[m][f][w] = wd;
        else e.rdata = mem_m[m][f][w];
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 16'h0, 0, 0, 0, "R10");
  endtask

  // Monitor: pops the item pushed before the previous edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (rsp_valid !== e.valid || upd_ack !== e.ack ||
            (e.valid && (rsp_code !== e.code || rsp_cur_gen !== e.gen || rsp_rdata !== e.rdata))) begin
          miscompares++;
          $display("FAIL %s: got v=%0b ack=%0b code=%0d gen=%0d rdata=%h exp v=%0b ack=%0b code=%0d gen=%0d rdata=%h",
                   e.tag, rsp_valid, upd_ack, rsp_code, rsp_cur_gen, rsp_rdata,
                   e.valid, e.ack, e.code, e.gen, e.rdata);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got run still busy, exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin gen_m[i] = 0; lock_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    vectors++;
    if (rsp_valid !== 1'b0 || upd_ack !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: got rsp_valid=%0b upd_ack=%0b exp 0 0", rsp_valid, upd_ack);
    end
    rst_n = 1'b1;

    // R1/R4: prefill frames 0..7 of both modules at count 0
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 8; f++)
        for (int w = 0; w < 8; w++)
          step(1, m, f, w, 1, 0, 16'(m * 4096 + f * 256 + w * 17), 0, 0, 0, "R1");
    // R4 readback, R9 separate banks
    step(1, 0, 5, 2, 0, 0, 16'h0, 0, 0, 0, "R4");
    step(1, 1, 5, 2, 0, 0, 16'h0, 0, 0, 0, "R9");
    // R3: stale write must not land
    step(1, 0, 5, 2, 1, 3, 16'hDEAD, 0, 0, 0, "R3");
    step(1, 0, 5, 2, 0, 0, 16'h0, 0, 0, 0, "R3");
    // R5/R8: bump frame 5, old count now stale, new count ok
    step(0, 0, 0, 0, 0, 0, 16'h0, 1, BUMP, 5, "R8");
    step(1, 0, 5, 1, 0, 0, 16'h0, 0, 0, 0, "R3");
    step(1, 1, 5, 1, 0, 1, 16'h0, 0, 0, 0, "R9");
    step(1, 0, 5, 1, 1, 1, 16'hBEEF, 0, 0, 0, "R2");
    // R5: wrap frame 9 through 16 bumps
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 0, 0, 16'h0, 1, BUMP, 9, "R5");
    step(1, 0, 9, 0, 1, 15, 16'h1111, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 16'h0, 1, BUMP, 9, "R5");
    step(1, 0, 9, 0, 1, 0, 16'h2222, 0, 0, 0, "R5");
    step(1, 0, 9, 0, 0, 15, 16'h0, 0, 0, 0, "R5");
    // R6: lock frame 7
    step(0, 0, 0, 0, 0, 0, 16'h0, 1, LOCK, 7, "R6");
    step(1, 0, 7, 3, 1, 1, 16'hBAD0, 0, 0, 0, "R6");
    step(1, 1, 7, 3, 0, 0, 16'h0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 16'h0, 1, UNLOCK, 7, "R6");
    step(1, 0, 7, 3, 0, 1, 16'h0, 0, 0, 0, "R6");
    // R7: same-cycle collisions on frame 5 (count 1 now)
    step(1, 0, 5, 4, 0, 1, 16'h0, 1, BUMP, 5, "R7");
    step(1, 0, 5, 4, 0, 3, 16'h0, 1, BUMP, 5, "R7");
    step(1, 1, 5, 4, 0, 3, 16'h0, 1, LOCK, 5, "R7");
    step(1, 0, 5, 4, 0, 4, 16'h0, 1, UNLOCK, 5, "R7");
    step(1, 0, 6, 4, 0, 0, 16'h0, 1, LOCK, 2, "R7");
    step(0, 0, 0, 0, 0, 0, 16'h0, 1, UNLOCK, 2, "R7");
    // R11: NOP acknowledged, nothing changed
    step(1, 0, 3, 0, 0, 0, 16'h0, 1, NOP, 3, "R11");
    step(1, 0, 3, 0, 0, 0, 16'h0, 0, 0, 0, "R11");
    idle();

    // Random mix over frames 0..7
    for (int i = 0; i < 2000; i++) begin
      int f, uf, op, g;
      bit rv, uv;
      f  = $urandom_range(0, 7);
      uf = $urandom_range(0, 7);
      rv = ($urandom_range(0, 3) != 0);
      uv = ($urandom_range(0, 3) == 0);
      op = $urandom_range(0, 3);
      g  = ($urandom_range(0, 2) != 0) ? gen_m[f] : int'($urandom_range(0, 15));
      if (uv && uf == f && (op == BUMP || op == LOCK) && $urandom_range(0, 1) == 1)
        g = (gen_m[f] + 1) % 16;
      step(rv, $urandom_range(0, 1), f, $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           g, 16'($urandom), uv, op, uf, "R2/R3/R7");
    end
    idle();
    idle();
    @(posedge clk);
    #2;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule